// File: doc/BRIEF.md
# AHB Bus Trace Monitor

This block sits beside a shared AHB fabric and watches the signals that come out of the bus multiplexers: the address and control of the master that holds the grant, and the data and response of the slave that is selected. It never drives the bus. For every cycle or transfer it is told to keep, it emits one trace frame with a valid strobe. Each frame holds the address, the control fields, both data buses, the response, the grant index of the owning master, a user sideband word (interrupt lines, core status or anything else the integrator wires in) and the value of a free-running cycle counter.

Two capture modes are available. In raw mode each clock is recorded exactly as it appears on the bus. In transfer mode the monitor keeps the address phase of a transfer in a register and joins it to the data phase when that phase completes, so one frame holds a whole transfer and a trigger can match address and data together. Raw mode can drop cycles that carry nothing: IDLE cycles, BUSY cycles and wait-state cycles. In either mode, an address window can limit capture to writes that land inside a programmed inclusive range. Frames go to an external trace sink, which is not part of this block.

Top module: `ahb_trace_mon`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, no frame is emitted. The cycle counter restarts from 0.
- R2: In raw mode (cfg_xfer_mode=0) with all filters off, every clock edge produces exactly one frame on the next cycle. Its address, trans, write, size, burst, write data, read data, response, master index and user fields equal the bus values sampled at that edge.
- R3: In transfer mode (cfg_xfer_mode=1) an address phase is one with trans NONSEQ (2) or SEQ (3) that is accepted with ready high. It produces a single frame at the first later edge where ready is high. That frame carries the address, trans, write, size, burst and master of the address phase, together with the write data, read data, response, user word and counter value of the completing edge.
- R4: In transfer mode, edges with ready low emit no frame, and the pending address phase is held unchanged until the data phase completes.
- R5: In transfer mode, IDLE (0) and BUSY (1) cycles open no transfer and so never produce a frame.
- R6: In raw mode with cfg_drop_idle=1, cycles whose trans is IDLE (0) produce no frame.
- R7: In raw mode with cfg_drop_busy=1, cycles whose trans is BUSY (1) produce no frame.
- R8: In raw mode with cfg_drop_wait=1, cycles with ready low produce no frame.
- R9: With cfg_win_en=1, a frame is kept only if its write bit is 1, its trans is NONSEQ or SEQ, and cfg_win_lo <= address <= cfg_win_hi, with both bounds inclusive. In transfer mode these are the address-phase values.
- R10: The counter advances by one on every clock edge out of reset and wraps modulo 2^TS_W. Each frame records the value the counter held at its capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Granted master's address |
| bus_trans | input | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| bus_write | input | 1 | Direction, 1 = write |
| bus_size | input | 3 | Transfer size |
| bus_burst | input | 3 | Burst type |
| bus_wdata | input | DW | Write data after the master multiplexer |
| bus_rdata | input | DW | Read data after the slave multiplexer |
| bus_ready | input | 1 | Transfer done / bus ready |
| bus_resp | input | 2 | Slave response |
| bus_master | input | MW | Grant index of the current master |
| user_sig | input | UW | User sideband signals |
| cfg_xfer_mode | input | 1 | 0 raw per-clock capture, 1 transfer capture |
| cfg_drop_idle | input | 1 | Raw mode: drop IDLE cycles |
| cfg_drop_busy | input | 1 | Raw mode: drop BUSY cycles |
| cfg_drop_wait | input | 1 | Raw mode: drop ready-low cycles |
| cfg_win_en | input | 1 | Enable the write address window |
| cfg_win_lo | input | AW | Window lower bound, inclusive |
| cfg_win_hi | input | AW | Window upper bound, inclusive |
| frm_valid | output | 1 | Frame strobe, one cycle per frame |
| frm_addr | output | AW | Frame address |
| frm_trans | output | 2 | Frame transfer type |
| frm_write | output | 1 | Frame direction |
| frm_size | output | 3 | Frame size |
| frm_burst | output | 3 | Frame burst type |
| frm_resp | output | 2 | Frame response |
| frm_master | output | MW | Master that owns the transfer |
| frm_wdata | output | DW | Frame write data |
| frm_rdata | output | DW | Frame read data |
| frm_user | output | UW | Frame user sideband |
| frm_tstamp | output | TS_W | Counter value at capture |

## Verification
The bench aims at the pipeline offset between address and data phases. It runs back-to-back transfers, a transfer stretched by wait states, an ERROR response that first appears with ready low, and a master change between two transfers. A monitor that paired the wrong phases would attach the previous transfer's data, or the new master's index, to a frame. It also includes BUSY and IDLE cycles that follow a pending transfer, which a monitor that opened a transfer on them would turn into spurious frames. The window is probed one below and one above each bound, and with reads and IDLE cycles whose write bit is set inside the range, which shows up off-by-one compares and a missing write or transfer check. A counter narrowed to 8 bits is run past its wrap, so a frame that latched the wrong edge's value, or a counter that saturated, is caught.

// File: rtl/trace_pkg.sv
package trace_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'd0,
        TR_BUSY   = 2'd1,
        TR_NONSEQ = 2'd2,
        TR_SEQ    = 2'd3
    } trans_e;

    // control fields fixed by the bus protocol
    typedef struct packed {
        logic [1:0] trans;
        logic       write;
        logic [2:0] size;
        logic [2:0] burst;
    } ctrl_t;

endpackage

// File: rtl/trace_tstamp.sv
module trace_tstamp #(
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TS_W-1:0] ts
);
    localparam logic [TS_W-1:0] STEP = TS_W'(1);

    typedef struct packed {
        logic [TS_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ts = st_q.cnt;

    AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ts == $past(ts) + STEP); // R10

endmodule

// File: rtl/trace_phase_align.sv
module trace_phase_align
    import trace_pkg::*;
#(
    parameter int AW = 32,
    parameter int MW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          xfer_mode,
    input  logic [AW-1:0] bus_addr,
    input  ctrl_t         bus_ctrl,
    input  logic [MW-1:0] bus_master,
    input  logic          bus_ready,
    output logic          cap_fire,
    output logic [AW-1:0] cap_addr,
    output ctrl_t         cap_ctrl,
    output logic [MW-1:0] cap_master
);
    typedef struct packed {
        logic          vld;
        logic [AW-1:0] addr;
        ctrl_t         ctrl;
        logic [MW-1:0] master;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!xfer_mode) begin
            st_d.vld = 1'b0;
        end else if (bus_ready) begin
            // a new address phase is accepted only while ready is high
            st_d.vld    = bus_ctrl.trans[1];
            st_d.addr   = bus_addr;
            st_d.ctrl   = bus_ctrl;
            st_d.master = bus_master;
        end

        if (xfer_mode) begin
            cap_fire   = st_q.vld && bus_ready;
            cap_addr   = st_q.addr;
            cap_ctrl   = st_q.ctrl;
            cap_master = st_q.master;
        end else begin
            cap_fire   = 1'b1;
            cap_addr   = bus_addr;
            cap_ctrl   = bus_ctrl;
            cap_master = bus_master;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_mode && st_q.vld && !bus_ready) |=>
        (st_q.vld && st_q.addr == $past(st_q.addr) && st_q.master == $past(st_q.master))); // R4

endmodule

// File: rtl/trace_filter.sv
module trace_filter
    import trace_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          xfer_mode,
    input  logic          cap_fire,
    input  logic [AW-1:0] cap_addr,
    input  logic [1:0]    cap_trans,
    input  logic          cap_write,
    input  logic          bus_ready,
    input  logic          drop_idle,
    input  logic          drop_busy,
    input  logic          drop_wait,
    input  logic          win_en,
    input  logic [AW-1:0] win_lo,
    input  logic [AW-1:0] win_hi,
    output logic          keep
);
    logic raw_drop;
    logic in_win;

    always_comb begin
        raw_drop = 1'b0;
        if (!xfer_mode) begin
            raw_drop = (drop_idle && cap_trans == TR_IDLE) ||
                       (drop_busy && cap_trans == TR_BUSY) ||
                       (drop_wait && !bus_ready);
        end
        in_win = cap_write && cap_trans[1] &&
                 (cap_addr >= win_lo) && (cap_addr <= win_hi);
        keep   = cap_fire && !raw_drop && (!win_en || in_win);
    end

endmodule

// File: rtl/ahb_trace_mon.sv
module ahb_trace_mon
    import trace_pkg::*;
#(
    parameter int AW   = 32,
    parameter int DW   = 32,
    parameter int MW   = 4,
    parameter int UW   = 8,
    parameter int TS_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   bus_addr,
    input  logic [1:0]      bus_trans,
    input  logic            bus_write,
    input  logic [2:0]      bus_size,
    input  logic [2:0]      bus_burst,
    input  logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    input  logic            bus_ready,
    input  logic [1:0]      bus_resp,
    input  logic [MW-1:0]   bus_master,
    input  logic [UW-1:0]   user_sig,
    input  logic            cfg_xfer_mode,
    input  logic            cfg_drop_idle,
    input  logic            cfg_drop_busy,
    input  logic            cfg_drop_wait,
    input  logic            cfg_win_en,
    input  logic [AW-1:0]   cfg_win_lo,
    input  logic [AW-1:0]   cfg_win_hi,
    output logic            frm_valid,
    output logic [AW-1:0]   frm_addr,
    output logic [1:0]      frm_trans,
    output logic            frm_write,
    output logic [2:0]      frm_size,
    output logic [2:0]      frm_burst,
    output logic [1:0]      frm_resp,
    output logic [MW-1:0]   frm_master,
    output logic [DW-1:0]   frm_wdata,
    output logic [DW-1:0]   frm_rdata,
    output logic [UW-1:0]   frm_user,
    output logic [TS_W-1:0] frm_tstamp
);
    typedef struct packed {
        logic            vld;
        logic [AW-1:0]   addr;
        ctrl_t           ctrl;
        logic [1:0]      resp;
        logic [MW-1:0]   master;
        logic [DW-1:0]   wdata;
        logic [DW-1:0]   rdata;
        logic [UW-1:0]   user;
        logic [TS_W-1:0] ts;
    } frame_t;

    ctrl_t           bus_ctrl;
    ctrl_t           cap_ctrl;
    logic [AW-1:0]   cap_addr;
    logic [MW-1:0]   cap_master;
    logic            cap_fire;
    logic            keep;
    logic [TS_W-1:0] ts_now;
    frame_t          fr_d, fr_q;

    assign bus_ctrl = '{trans: bus_trans, write: bus_write, size: bus_size, burst: bus_burst};

    trace_tstamp #(.TS_W(TS_W)) u_tstamp (
        .clk   (clk),
        .rst_n (rst_n),
        .ts    (ts_now)
    );

    trace_phase_align #(.AW(AW), .MW(MW)) u_align (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_mode  (cfg_xfer_mode),
        .bus_addr   (bus_addr),
        .bus_ctrl   (bus_ctrl),
        .bus_master (bus_master),
        .bus_ready  (bus_ready),
        .cap_fire   (cap_fire),
        .cap_addr   (cap_addr),
        .cap_ctrl   (cap_ctrl),
        .cap_master (cap_master)
    );

    trace_filter #(.AW(AW)) u_filter (
        .xfer_mode (cfg_xfer_mode),
        .cap_fire  (cap_fire),
        .cap_addr  (cap_addr),
        .cap_trans (cap_ctrl.trans),
        .cap_write (cap_ctrl.write),
        .bus_ready (bus_ready),
        .drop_idle (cfg_drop_idle),
        .drop_busy (cfg_drop_busy),
        .drop_wait (cfg_drop_wait),
        .win_en    (cfg_win_en),
        .win_lo    (cfg_win_lo),
        .win_hi    (cfg_win_hi),
        .keep      (keep)
    );

    always_comb begin
        fr_d     = fr_q;
        fr_d.vld = keep;
        if (keep) begin
            fr_d.addr   = cap_addr;
            fr_d.ctrl   = cap_ctrl;
            fr_d.master = cap_master;
            fr_d.resp   = bus_resp;
            fr_d.wdata  = bus_wdata;
            fr_d.rdata  = bus_rdata;
            fr_d.user   = user_sig;
            fr_d.ts     = ts_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    assign frm_valid  = fr_q.vld;
    assign frm_addr   = fr_q.addr;
    assign frm_trans  = fr_q.ctrl.trans;
    assign frm_write  = fr_q.ctrl.write;
    assign frm_size   = fr_q.ctrl.size;
    assign frm_burst  = fr_q.ctrl.burst;
    assign frm_resp   = fr_q.resp;
    assign frm_master = fr_q.master;
    assign frm_wdata  = fr_q.wdata;
    assign frm_rdata  = fr_q.rdata;
    assign frm_user   = fr_q.user;
    assign frm_tstamp = fr_q.ts;

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !frm_valid); // R1
    AST_XFER_REAL: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && $past(cfg_xfer_mode)) |-> frm_trans[1]); // R5
    AST_DROP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && $past(!cfg_xfer_mode && cfg_drop_idle)) |-> frm_trans != TR_IDLE); // R6
    AST_DROP_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && $past(!cfg_xfer_mode && cfg_drop_wait)) |-> $past(bus_ready)); // R8
    AST_WIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_valid && $past(cfg_win_en)) |->
        (frm_write && frm_addr >= $past(cfg_win_lo) && frm_addr <= $past(cfg_win_hi))); // R9

endmodule

// File: tb/ahb_trace_mon_tb.sv
module ahb_trace_mon_tb;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int MW = 2;
    localparam int UW = 4;
    localparam int TW = 8;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_trans;
    logic          bus_write;
    logic [2:0]    bus_size, bus_burst;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic          bus_ready;
    logic [1:0]    bus_resp;
    logic [MW-1:0] bus_master;
    logic [UW-1:0] user_sig;
    logic          cfg_xfer_mode, cfg_drop_idle, cfg_drop_busy, cfg_drop_wait, cfg_win_en;
    logic [AW-1:0] cfg_win_lo, cfg_win_hi;
    logic          frm_valid;
    logic [AW-1:0] frm_addr;
    logic [1:0]    frm_trans;
    logic          frm_write;
    logic [2:0]    frm_size, frm_burst;
    logic [1:0]    frm_resp;
    logic [MW-1:0] frm_master;
    logic [DW-1:0] frm_wdata, frm_rdata;
    logic [UW-1:0] frm_user;
    logic [TW-1:0] frm_tstamp;

    ahb_trace_mon #(.AW(AW), .DW(DW), .MW(MW), .UW(UW), .TS_W(TW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_trans(bus_trans), .bus_write(bus_write),
        .bus_size(bus_size), .bus_burst(bus_burst), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready), .bus_resp(bus_resp),
        .bus_master(bus_master), .user_sig(user_sig),
        .cfg_xfer_mode(cfg_xfer_mode), .cfg_drop_idle(cfg_drop_idle),
        .cfg_drop_busy(cfg_drop_busy), .cfg_drop_wait(cfg_drop_wait),
        .cfg_win_en(cfg_win_en), .cfg_win_lo(cfg_win_lo), .cfg_win_hi(cfg_win_hi),
        .frm_valid(frm_valid), .frm_addr(frm_addr), .frm_trans(frm_trans),
        .frm_write(frm_write), .frm_size(frm_size), .frm_burst(frm_burst),
        .frm_resp(frm_resp), .frm_master(frm_master), .frm_wdata(frm_wdata),
        .frm_rdata(frm_rdata), .frm_user(frm_user), .frm_tstamp(frm_tstamp)
    );

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [1:0]    trans;
        logic          write;
        logic [2:0]    size;
        logic [2:0]    burst;
        logic [1:0]    resp;
        logic [MW-1:0] master;
        logic [DW-1:0] wdata;
        logic [DW-1:0] rdata;
        logic [UW-1:0] user;
        logic [TW-1:0] ts;
    } frm_t;

    frm_t  exp_q[$];
    frm_t  got_f, exp_f;
    int    n_chk = 0;
    int    n_bad = 0;
    string cur_tag = "R1";
    logic  [TW-1:0] edge_cnt;

    // next configuration, applied by the driver at its drive point
    logic          nx_xfer = 1'b0, nx_idle = 1'b1, nx_busy = 1'b0, nx_wait = 1'b0, nx_win = 1'b0;
    logic [AW-1:0] nx_lo = '0, nx_hi = '0;

    // bench model of the pending address phase
    logic          p_v = 1'b0;
    logic [AW-1:0] p_addr;
    logic [1:0]    p_trans;
    logic          p_write;
    logic [2:0]    p_size, p_burst;
    logic [MW-1:0] p_master;

    always @(posedge clk) begin
        if (!rst_n) edge_cnt <= '0;
        else        edge_cnt <= edge_cnt + 1'b1;
    end

    function automatic logic win_ok(logic [1:0] tr, logic wr, logic [AW-1:0] a);
        return !cfg_win_en || (wr && tr[1] && a >= cfg_win_lo && a <= cfg_win_hi);
    endfunction

    task automatic cyc(input logic [1:0] tr, input logic wr, input logic [AW-1:0] ad,
                       input logic rdy, input logic [DW-1:0] wd, input logic [DW-1:0] rd,
                       input logic [1:0] rs, input logic [MW-1:0] ms, input logic [UW-1:0] us,
                       input string tag);
        frm_t f;
        logic keep;
        @(negedge clk);
        cfg_xfer_mode = nx_xfer; cfg_drop_idle = nx_idle; cfg_drop_busy = nx_busy;
        cfg_drop_wait = nx_wait; cfg_win_en = nx_win; cfg_win_lo = nx_lo; cfg_win_hi = nx_hi;
        bus_trans = tr; bus_write = wr; bus_addr = ad; bus_ready = rdy;
        bus_wdata = wd; bus_rdata = rd; bus_resp = rs; bus_master = ms; user_sig = us;
        bus_size = wd[2:0]; bus_burst = ad[6:4];
        cur_tag = tag;
        if (!cfg_xfer_mode) begin
            keep = !(cfg_drop_idle && tr == 2'd0) && !(cfg_drop_busy && tr == 2'd1) &&
                   !(cfg_drop_wait && !rdy) && win_ok(tr, wr, ad);
            if (keep) begin
                f = '{ad, tr, wr, wd[2:0], ad[6:4], rs, ms, wd, rd, us, edge_cnt};
                exp_q.push_back(f);
            end
            p_v = 1'b0;
        end else begin
            if (p_v && rdy && win_ok(p_trans, p_write, p_addr)) begin
                f = '{p_addr, p_trans, p_write, p_size, p_burst, rs, p_master, wd, rd, us, edge_cnt};
                exp_q.push_back(f);
            end
            if (rdy) begin
                p_v = tr[1]; p_addr = ad; p_trans = tr; p_write = wr;
                p_size = wd[2:0]; p_burst = ad[6:4]; p_master = ms;
            end
        end
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(2'd0, 1'b0, '0, 1'b1, '0, '0, 2'd0, '0, '0, tag);
    endtask

    task automatic run_mix(input string tag);
        cyc(2'd0, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'h0000, 2'd0, 2'd0, 4'h0, tag);
        cyc(2'd2, 1'b1, 16'h0100, 1'b1, 16'h1111, 16'h0000, 2'd0, 2'd1, 4'h1, tag);
        cyc(2'd3, 1'b1, 16'h0104, 1'b0, 16'h2222, 16'h0000, 2'd0, 2'd1, 4'h2, tag);
        cyc(2'd3, 1'b1, 16'h0104, 1'b1, 16'h2223, 16'h0000, 2'd0, 2'd1, 4'h3, tag);
        cyc(2'd1, 1'b1, 16'h0108, 1'b1, 16'h3333, 16'h0000, 2'd0, 2'd1, 4'h4, tag);
        cyc(2'd2, 1'b0, 16'h0200, 1'b1, 16'h4444, 16'h0000, 2'd0, 2'd2, 4'h5, tag);
        cyc(2'd0, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'hBEEF, 2'd0, 2'd2, 4'h6, tag);
        cyc(2'd0, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'hCAFE, 2'd0, 2'd0, 4'h7, tag);
    endtask

    task automatic report(input string msg);
        n_bad++;
        $display("FAIL %s %s: got %h exp %h", cur_tag, msg, got_f, exp_f);
    endtask

    // scoreboard monitor, samples 5 ns after each rising edge
    always @(posedge clk) begin
        #5;
        if (rst_n) begin
            got_f = '{frm_addr, frm_trans, frm_write, frm_size, frm_burst, frm_resp,
                      frm_master, frm_wdata, frm_rdata, frm_user, frm_tstamp};
            n_chk++;
            if (frm_valid) begin
                if (exp_q.size() == 0) begin
                    exp_f = '0;
                    report("unexpected frame");
                end else begin
                    exp_f = exp_q.pop_front();
                    if (got_f !== exp_f) report("frame mismatch");
                end
            end else if (exp_q.size() != 0) begin
                exp_f = exp_q.pop_front();
                got_f = '0;
                report("missing frame");
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog: got hung exp finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        bus_addr = '0; bus_trans = '0; bus_write = 1'b0; bus_size = '0; bus_burst = '0;
        bus_wdata = '0; bus_rdata = '0; bus_ready = 1'b1; bus_resp = '0; bus_master = '0;
        user_sig = '0;
        cfg_xfer_mode = 1'b0; cfg_drop_idle = 1'b1; cfg_drop_busy = 1'b0;
        cfg_drop_wait = 1'b0; cfg_win_en = 1'b0; cfg_win_lo = '0; cfg_win_hi = '0;
        // R1: quiet during reset
        for (int i = 0; i < 4; i++) begin
            @(posedge clk); #5;
            n_chk++;
            if (frm_valid !== 1'b0) begin
                n_bad++;
                $display("FAIL R1 valid during reset: got %b exp 0", frm_valid);
            end
        end
        @(negedge clk);
        rst_n = 1'b1;
        idle(2, "R1");

        // R2: raw capture, no filter
        nx_idle = 1'b0;
        run_mix("R2");
        // R6 / R7 / R8: raw filters one at a time
        nx_idle = 1'b1; run_mix("R6");
        nx_idle = 1'b0; nx_busy = 1'b1; run_mix("R7");
        nx_busy = 1'b0; nx_wait = 1'b1; run_mix("R8");
        nx_wait = 1'b0; nx_idle = 1'b1;
        idle(1, "R6");

        // R3 / R4 / R5: transfer mode pairing
        nx_xfer = 1'b1;
        idle(1, "R5");
        cyc(2'd2, 1'b1, 16'h1000, 1'b1, 16'h0000, 16'h0000, 2'd0, 2'd1, 4'h1, "R3");
        cyc(2'd3, 1'b1, 16'h1004, 1'b0, 16'hAAA9, 16'h0000, 2'd0, 2'd1, 4'h2, "R4");
        cyc(2'd3, 1'b1, 16'h1004, 1'b1, 16'hAAAA, 16'h0000, 2'd0, 2'd1, 4'h3, "R3");
        cyc(2'd1, 1'b1, 16'h1008, 1'b1, 16'hBBBB, 16'h0000, 2'd0, 2'd1, 4'h4, "R3");
        cyc(2'd2, 1'b0, 16'h2000, 1'b1, 16'h0000, 16'h0000, 2'd0, 2'd2, 4'h5, "R5");
        cyc(2'd0, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h1234, 2'd0, 2'd0, 4'h6, "R4");
        cyc(2'd0, 1'b0, 16'h0000, 1'b0, 16'h0000, 16'h1235, 2'd0, 2'd0, 4'h7, "R4");
        cyc(2'd0, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'h5678, 2'd0, 2'd0, 4'h9, "R3");
        cyc(2'd0, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'h0000, 2'd0, 2'd0, 4'h0, "R5");
        cyc(2'd2, 1'b1, 16'h3000, 1'b1, 16'h0000, 16'h0000, 2'd0, 2'd3, 4'h1, "R3");
        cyc(2'd2, 1'b1, 16'h3008, 1'b1, 16'h3131, 16'h0000, 2'd0, 2'd1, 4'h2, "R3");
        cyc(2'd0, 1'b0, 16'h0000, 1'b0, 16'h3232, 16'h0000, 2'd1, 2'd0, 4'h3, "R4");
        cyc(2'd0, 1'b0, 16'h0000, 1'b1, 16'h3233, 16'h0000, 2'd1, 2'd0, 4'h4, "R3");
        cyc(2'd1, 1'b0, 16'h0000, 1'b1, 16'h0000, 16'h0000, 2'd0, 2'd0, 4'h5, "R5");
        idle(2, "R5");

        // R9: window in transfer mode, bounds and reads
        nx_win = 1'b1; nx_lo = 16'h4000; nx_hi = 16'h40FF;
        cyc(2'd2, 1'b1, 16'h3FFF, 1'b1, 16'h0001, 16'h0000, 2'd0, 2'd1, 4'h1, "R9");
        cyc(2'd2, 1'b1, 16'h4000, 1'b1, 16'h0002, 16'h0000, 2'd0, 2'd1, 4'h2, "R9");
        cyc(2'd3, 1'b1, 16'h40FF, 1'b1, 16'h0003, 16'h0000, 2'd0, 2'd1, 4'h3, "R9");
        cyc(2'd2, 1'b1, 16'h4100, 1'b1, 16'h0004, 16'h0000, 2'd0, 2'd2, 4'h4, "R9");
        cyc(2'd2, 1'b0, 16'h4080, 1'b1, 16'h0005, 16'h0000, 2'd0, 2'd2, 4'h5, "R9");
        cyc(2'd2, 1'b1, 16'h4080, 1'b1, 16'h0006, 16'h7777, 2'd0, 2'd3, 4'h6, "R9");
        cyc(2'd0, 1'b0, 16'h0000, 1'b1, 16'h0007, 16'h0000, 2'd0, 2'd0, 4'h7, "R9");
        // R9: window in raw mode, IDLE with write set is not a write access
        nx_xfer = 1'b0; nx_idle = 1'b0;
        cyc(2'd2, 1'b1, 16'h4010, 1'b1, 16'h0011, 16'h0000, 2'd0, 2'd1, 4'h1, "R9");
        cyc(2'd0, 1'b1, 16'h4020, 1'b1, 16'h0012, 16'h0000, 2'd0, 2'd1, 4'h2, "R9");
        cyc(2'd2, 1'b0, 16'h4030, 1'b1, 16'h0013, 16'h0000, 2'd0, 2'd1, 4'h3, "R9");
        cyc(2'd3, 1'b1, 16'h40FF, 1'b1, 16'h0014, 16'h0000, 2'd0, 2'd1, 4'h4, "R9");
        cyc(2'd2, 1'b1, 16'h4100, 1'b1, 16'h0015, 16'h0000, 2'd0, 2'd1, 4'h5, "R9");
        nx_win = 1'b0; nx_idle = 1'b1;

        // R10: counter wraps past 2^TW
        idle(300, "R10");
        cyc(2'd2, 1'b1, 16'h0055, 1'b1, 16'h5555, 16'h0000, 2'd0, 2'd1, 4'hA, "R10");
        cyc(2'd3, 1'b1, 16'h0059, 1'b1, 16'h5656, 16'h0000, 2'd0, 2'd2, 4'hB, "R10");
        idle(3, "R10");
        @(posedge clk); #6;

        if (exp_q.size() != 0) begin
            n_chk++; n_bad++;
            $display("FAIL R2 leftover frames: got %0d exp 0", exp_q.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule